// File: doc/BRIEF.md
# Packed Integer Dot-Product Unit

The unit multiplies two four-lane integer vectors lane by lane and adds the four products into one result word. Lanes are read as signed or unsigned under a per-operation select. Two further selects set how the additions are grouped and how overflow is treated. Integer adds without overflow handling give the same answer in any grouping. Once overflow is detected or saturated, the grouping changes both the flags and the result.

Operands enter through a valid/ready handshake. The unit is a three-stage pipeline with a global stall. The result, an overflow flag and a saturation flag leave through a second valid/ready handshake, and the output holds while the consumer is not ready. With the output ready held high, the unit accepts one operation per cycle. Each result appears three cycles after its operands are accepted.

Top module: `dot4_unit`

## Requirements
- R1: Lane i of `a_i` and `b_i` is bits [16i+15:16i]. Each product pi = ai*bi is exact. When `signed_i`=1, lanes are sign-extended; when `signed_i`=0, lanes are zero-extended.
- R2: When `ovf_mode_i` is 0 or 3 (wrap), `result_o` is the exact sum of the four products modulo 2^32. `ovf_o` and `sat_o` are 0. `tree_i` and `sticky_i` have no effect.
- R3: When `ovf_mode_i`=1 (wide), the sum is formed exactly and range-checked only once, at the end. If the sum is out of range, `result_o` is the nearer limit and `ovf_o`=`sat_o`=1. An intermediate excursion that the remaining terms cancel raises no flag.
- R4: When `ovf_mode_i`=2 (stepwise) and `tree_i`=0, the grouping is ((p0+p1)+p2)+p3. Each of the three adds is range-checked, and an out-of-range add is clamped to the limit before the next add.
- R5: When `ovf_mode_i`=2 and `tree_i`=1, the grouping is (p0+p1)+(p2+p3), with each of the three adds checked and clamped. `sticky_i` has no effect in this grouping.
- R6: When `ovf_mode_i`=2, `tree_i`=0 and `sticky_i`=1, a partial sum that has clamped stays at that limit. The later terms are ignored, and `sat_o`=1.
- R7: When `ovf_mode_i`=2, `tree_i`=0 and `sticky_i`=0, a clamped partial sum keeps accumulating later terms. `ovf_o`=1, and `sat_o` is 1 only if the last add clamped.
- R8: The limits for `signed_i`=1 are 0x7FFFFFFF and 0x80000000. The limits for `signed_i`=0 are 0xFFFFFFFF and 0x00000000.
- R9: `ovf_o` is 1 exactly when some checked add went out of range. `sat_o`=1 is never reported without `ovf_o`=1.
- R10: With `out_ready_i` high, operands accepted at one clock edge produce `out_valid_o` and the result after the third edge. One operation can be accepted per cycle.
- R11: While `out_valid_o`=1 and `out_ready_i`=0, the result and both flags hold, `out_valid_o` stays 1 and `in_ready_o` is 0.
- R12: While `rst_ni` is low and just after reset, `out_valid_o`=0 and `in_ready_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Operands valid |
| in_ready_o | output | 1 | Unit can take operands |
| a_i | input | 64 | Four packed lanes of vector A |
| b_i | input | 64 | Four packed lanes of vector B |
| signed_i | input | 1 | 1: signed lanes and limits; 0: unsigned |
| tree_i | input | 1 | 1: pairwise grouping; 0: left-to-right |
| ovf_mode_i | input | 2 | 0/3 wrap, 1 wide, 2 stepwise |
| sticky_i | input | 1 | Pin clamped partial sums (left-to-right stepwise) |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes the result |
| result_o | output | 32 | Dot-product result |
| ovf_o | output | 1 | Overflow detected |
| sat_o | output | 1 | Result equals a clamped or pinned limit |

## Verification
With the output always ready, each result is due on the third clock edge after its operands are accepted. The bench stores that edge number with the expected value and checks, when the result leaves, that it left at exactly that edge. In the back-pressure phase the timing check is turned off. Instead, the bench checks on every cycle that a stalled output still holds its previous value, and checks results only in acceptance order. Expected values come from an arithmetic model that uses 64-bit integers, fed with directed cases that separate the groupings and the sticky policy.

// File: rtl/dot4_pkg.sv
package dot4_pkg;

  typedef enum logic [1:0] {
    OVF_WRAP = 2'd0,
    OVF_WIDE = 2'd1,
    OVF_STEP = 2'd2,
    OVF_RSVD = 2'd3
  } ovf_mode_e;

  typedef struct packed {
    logic      sgn;
    logic      tree;
    ovf_mode_e mode;
    logic      sticky;
  } ctrl_t;

endpackage

// File: rtl/dot4_prod_stage.sv
module dot4_prod_stage #(
  parameter int LANES  = 4,
  parameter int ELEM_W = 16,
  parameter int SUM_W  = 35
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic                   valid_i,
  input  logic                   sgn_i,
  input  logic [LANES*ELEM_W-1:0] a_i,
  input  logic [LANES*ELEM_W-1:0] b_i,
  output logic [LANES*SUM_W-1:0]  prod_o,
  output logic                   valid_o
);

  localparam int EXT_W = SUM_W - ELEM_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [ELEM_W-1:0]       a_el, b_el;
    logic signed [SUM_W-1:0] a_ext, b_ext, prod_d;
    logic [SUM_W-1:0]        prod_q;

    assign a_el   = a_i[g*ELEM_W +: ELEM_W];
    assign b_el   = b_i[g*ELEM_W +: ELEM_W];
    // sign bit replicated only in signed mode
    assign a_ext  = {{EXT_W{sgn_i & a_el[ELEM_W-1]}}, a_el};
    assign b_ext  = {{EXT_W{sgn_i & b_el[ELEM_W-1]}}, b_el};
    assign prod_d = a_ext * b_ext;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   prod_q <= '0;
      else if (en_i) prod_q <= prod_d;
    end

    assign prod_o[g*SUM_W +: SUM_W] = prod_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_o <= 1'b0;
    else if (en_i) valid_o <= valid_i;
  end

endmodule

// File: rtl/dot4_step_add.sv
module dot4_step_add #(
  parameter int RES_W = 32,
  parameter int SUM_W = 35
) (
  input  logic signed [SUM_W-1:0] x_i,
  input  logic signed [SUM_W-1:0] y_i,
  input  logic                    sgn_i,
  input  logic                    chk_i,
  input  logic                    pin_i,
  output logic signed [SUM_W-1:0] sum_o,
  output logic                    ovf_o,
  output logic                    sat_o
);

  localparam logic [SUM_W-1:0] ONE = SUM_W'(1);
  localparam logic signed [SUM_W-1:0] S_HI = $signed((ONE << (RES_W-1)) - ONE);
  localparam logic signed [SUM_W-1:0] S_LO = -$signed(ONE << (RES_W-1));
  localparam logic signed [SUM_W-1:0] U_HI = $signed((ONE << RES_W) - ONE);
  localparam logic signed [SUM_W-1:0] U_LO = '0;

  logic signed [SUM_W-1:0] raw, hi, lo;

  assign raw = x_i + y_i;
  assign hi  = sgn_i ? S_HI : U_HI;
  assign lo  = sgn_i ? S_LO : U_LO;

  always_comb begin
    sum_o = raw;
    ovf_o = 1'b0;
    sat_o = 1'b0;
    if (pin_i) begin
      sum_o = x_i;        // operand already pinned at a limit
      sat_o = 1'b1;
    end else if (chk_i && (raw > hi)) begin
      sum_o = hi;
      ovf_o = 1'b1;
      sat_o = 1'b1;
    end else if (chk_i && (raw < lo)) begin
      sum_o = lo;
      ovf_o = 1'b1;
      sat_o = 1'b1;
    end
  end

endmodule

// File: rtl/dot4_unit.sv
module dot4_unit #(
  parameter int ELEM_W = 16,
  parameter int RES_W  = 32,
  localparam int LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    in_valid_i,
  output logic                    in_ready_o,
  input  logic [LANES*ELEM_W-1:0] a_i,
  input  logic [LANES*ELEM_W-1:0] b_i,
  input  logic                    signed_i,
  input  logic                    tree_i,
  input  logic [1:0]              ovf_mode_i,
  input  logic                    sticky_i,
  output logic                    out_valid_o,
  input  logic                    out_ready_i,
  output logic [RES_W-1:0]        result_o,
  output logic                    ovf_o,
  output logic                    sat_o
);
  import dot4_pkg::*;

  // headroom for four unclamped products
  localparam int SUM_W = RES_W + 3;

  logic adv;
  assign adv        = !(out_valid_o && !out_ready_i);
  assign in_ready_o = adv;

  // stage 1: products
  logic [LANES*SUM_W-1:0] prod;
  logic                   v1;
  ctrl_t                  ctrl1;

  dot4_prod_stage #(.LANES(LANES), .ELEM_W(ELEM_W), .SUM_W(SUM_W)) u_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (adv),
    .valid_i (in_valid_i),
    .sgn_i   (signed_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .prod_o  (prod),
    .valid_o (v1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl1 <= '0;
    else if (adv) ctrl1 <= '{sgn: signed_i, tree: tree_i,
                             mode: ovf_mode_e'(ovf_mode_i), sticky: sticky_i};
  end

  // stage 2: first two adds
  logic signed [SUM_W-1:0] p0, p1, p2, p3;
  assign p0 = prod[0*SUM_W +: SUM_W];
  assign p1 = prod[1*SUM_W +: SUM_W];
  assign p2 = prod[2*SUM_W +: SUM_W];
  assign p3 = prod[3*SUM_W +: SUM_W];

  logic step1;
  assign step1 = (ctrl1.mode == OVF_STEP);

  logic signed [SUM_W-1:0] sum_a, sum_b, bx, by;
  logic ovf_a, sat_a, ovf_b, sat_b, pin_b;

  dot4_step_add #(.RES_W(RES_W), .SUM_W(SUM_W)) u_add_a (
    .x_i(p0), .y_i(p1), .sgn_i(ctrl1.sgn), .chk_i(step1), .pin_i(1'b0),
    .sum_o(sum_a), .ovf_o(ovf_a), .sat_o(sat_a)
  );

  assign bx    = ctrl1.tree ? p2 : sum_a;
  assign by    = ctrl1.tree ? p3 : p2;
  assign pin_b = step1 && !ctrl1.tree && ctrl1.sticky && sat_a;

  dot4_step_add #(.RES_W(RES_W), .SUM_W(SUM_W)) u_add_b (
    .x_i(bx), .y_i(by), .sgn_i(ctrl1.sgn), .chk_i(step1), .pin_i(pin_b),
    .sum_o(sum_b), .ovf_o(ovf_b), .sat_o(sat_b)
  );

  logic [SUM_W-1:0] x2, y2;
  logic             satx2, ovf2, v2;
  ctrl_t            ctrl2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x2 <= '0; y2 <= '0; satx2 <= 1'b0; ovf2 <= 1'b0; v2 <= 1'b0; ctrl2 <= '0;
    end else if (adv) begin
      x2    <= ctrl1.tree ? sum_a : sum_b;
      y2    <= ctrl1.tree ? sum_b : p3;
      satx2 <= ctrl1.tree ? 1'b0 : sat_b;
      ovf2  <= ovf_a | ovf_b;
      v2    <= v1;
      ctrl2 <= ctrl1;
    end
  end

  // stage 3: final add and range check
  logic signed [SUM_W-1:0] sum_c;
  logic ovf_c, sat_c, chk_c, pin_c;

  assign chk_c = (ctrl2.mode == OVF_STEP) || (ctrl2.mode == OVF_WIDE);
  assign pin_c = (ctrl2.mode == OVF_STEP) && !ctrl2.tree && ctrl2.sticky && satx2;

  dot4_step_add #(.RES_W(RES_W), .SUM_W(SUM_W)) u_add_c (
    .x_i($signed(x2)), .y_i($signed(y2)), .sgn_i(ctrl2.sgn), .chk_i(chk_c),
    .pin_i(pin_c), .sum_o(sum_c), .ovf_o(ovf_c), .sat_o(sat_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0; result_o <= '0; ovf_o <= 1'b0; sat_o <= 1'b0;
    end else if (adv) begin
      out_valid_o <= v2;
      result_o    <= sum_c[RES_W-1:0];
      ovf_o       <= ovf2 | ovf_c;
      sat_o       <= sat_c;
    end
  end

endmodule

// File: rtl/dot4_unit_chk.sv
module dot4_unit_chk #(
  parameter int RES_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             in_valid_i,
  input logic             in_ready_o,
  input logic             out_valid_o,
  input logic             out_ready_i,
  input logic [RES_W-1:0] result_o,
  input logic             ovf_o,
  input logic             sat_o
);

  logic [1:0] age;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R12
  always @(posedge clk_i) begin
    if (!rst_ni) reset_idle_chk: assert (!out_valid_o && in_ready_o);
  end

  // R9
  sat_implies_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && sat_o |-> ovf_o);

  // R11
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(result_o) &&
                                    $stable(ovf_o) && $stable(sat_o));

  // R11
  stall_blocks_in_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);

  // R10
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd3) && $past(in_valid_i && in_ready_o, 3) &&
    $past(out_ready_i, 2) && $past(out_ready_i, 1) |-> out_valid_o);

endmodule

bind dot4_unit dot4_unit_chk #(.RES_W(RES_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .result_o    (result_o),
  .ovf_o       (ovf_o),
  .sat_o       (sat_o)
);

// File: tb/dot4_unit_tb_top.sv
`timescale 1ns/1ps
module dot4_unit_tb_top;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    logic        sat;
    int          due;
    bit          timed;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] a = '0, b = '0;
  logic        sgn = 1'b0, tree = 1'b0, sticky = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        out_valid, out_ready = 1'b1;
  logic [31:0] result;
  logic        ovf, sat;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    cur_timed = 1'b1, bp_en = 1'b0;
  string cur_tag = "R1";
  exp_t  q[$];
  bit    prev_stall = 1'b0;
  logic [33:0] prev_out = '0;

  always #10 clk = ~clk;   // 50 MHz

  dot4_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .a_i(a), .b_i(b), .signed_i(sgn), .tree_i(tree), .ovf_mode_i(mode),
    .sticky_i(sticky), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .result_o(result), .ovf_o(ovf), .sat_o(sat)
  );

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  function automatic longint clampv(longint v, longint hi, longint lo, output bit c);
    c = 1'b0;
    if (v > hi) begin c = 1'b1; return hi; end
    if (v < lo) begin c = 1'b1; return lo; end
    return v;
  endfunction

  function automatic exp_t model(logic [63:0] av, logic [63:0] bv, logic s, logic t,
                                 logic [1:0] m, logic st);
    exp_t   e;
    longint p[4];
    longint hi, lo, acc, tot, t0, t1;
    bit     c, c0, c1, pinned;
    for (int i = 0; i < 4; i++) begin
      longint ea, eb;
      ea = s ? longint'($signed(av[16*i +: 16])) : longint'(av[16*i +: 16]);
      eb = s ? longint'($signed(bv[16*i +: 16])) : longint'(bv[16*i +: 16]);
      p[i] = ea * eb;
    end
    hi = s ? 64'sh7FFFFFFF : 64'shFFFFFFFF;
    lo = s ? -64'sh80000000 : 64'sh0;
    tot = p[0] + p[1] + p[2] + p[3];
    e.ovf = 1'b0; e.sat = 1'b0;
    if (m == 2'd1) begin
      acc = clampv(tot, hi, lo, c);
      e.ovf = c; e.sat = c;
    end else if (m == 2'd2 && t) begin
      t0  = clampv(p[0] + p[1], hi, lo, c0);
      t1  = clampv(p[2] + p[3], hi, lo, c1);
      acc = clampv(t0 + t1, hi, lo, c);
      e.ovf = c0 | c1 | c; e.sat = c;
    end else if (m == 2'd2) begin
      acc = p[0]; pinned = 1'b0;
      for (int k = 1; k < 4; k++) begin
        if (pinned && st) begin
          e.sat = 1'b1;
        end else begin
          acc = clampv(acc + p[k], hi, lo, c);
          e.sat = c;
          if (c) begin e.ovf = 1'b1; pinned = 1'b1; end
        end
      end
    end else begin
      acc = tot;
    end
    e.res = acc[31:0];
    return e;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // per-cycle monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_stall)  // R11 held output
        check(out_valid && {result, ovf, sat} == prev_out, "R11",
              {29'd0, out_valid, result, ovf, sat}, {29'd0, 1'b1, prev_out});
      if (out_valid && !out_ready)  // R11 input blocked
        check(!in_ready, "R11", {63'd0, in_ready}, 64'd0);
      if (out_valid && out_ready) begin
        if (q.size() == 0) begin
          check(1'b0, "R10", {32'd0, result}, 64'd0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check({result, ovf, sat} == {e.res, e.ovf, e.sat}, e.tag,
                {30'd0, result, ovf, sat}, {30'd0, e.res, e.ovf, e.sat});
          if (e.timed) check(cyc == e.due, "R10", 64'(cyc), 64'(e.due));
        end
      end
      if (in_valid && in_ready) begin
        exp_t e;
        e = model(a, b, sgn, tree, mode, sticky);
        e.due = cyc + 3; e.timed = cur_timed; e.tag = cur_tag;
        q.push_back(e);
      end
      prev_stall = out_valid && !out_ready;
      prev_out   = {result, ovf, sat};
    end
  end

  // back-pressure pattern
  always begin
    @(posedge clk); #1;
    if (bp_en) out_ready = ($urandom % 3) != 0;
  end

  task automatic send(logic [63:0] av, logic [63:0] bv, logic s, logic t,
                      logic [1:0] m, logic st, string tag);
    @(posedge clk); #1;
    in_valid = 1'b1; a = av; b = bv; sgn = s; tree = t; mode = m; sticky = st;
    cur_tag = tag;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
  endtask

  task automatic go_idle();
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && q.size() != 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [15:0] pick();
    case ($urandom % 4)
      0: return 16'h7FFF;
      1: return 16'h8000;
      2: return 16'hFFFF;
      default: return 16'($urandom);
    endcase
  endfunction

  function automatic logic [63:0] pickv();
    return {pick(), pick(), pick(), pick()};
  endfunction

  function automatic string tag_of(logic [1:0] m, logic t, logic st);
    if (m == 2'd1) return "R3";
    if (m == 2'd2 && t) return "R5";
    if (m == 2'd2 && st) return "R6";
    if (m == 2'd2) return "R4";
    return "R2";
  endfunction

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 64'(cyc), 64'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  // lane vectors: element 3 in the top bits
  localparam logic [63:0] V_SM_A = {16'hFFF9, 16'h0005, 16'hFFFE, 16'h0003};
  localparam logic [63:0] V_SM_B = {16'h0002, 16'hFFFF, 16'h0006, 16'h0004};
  localparam logic [63:0] V_MAXP = {4{16'h7FFF}};
  localparam logic [63:0] V_MINN = {4{16'h8000}};
  localparam logic [63:0] V_ALL1 = {4{16'hFFFF}};
  // p0=p1=2^30, p2=p3=-1073709056
  localparam logic [63:0] V_EX_A = {16'h8000, 16'h8000, 16'h8000, 16'h8000};
  localparam logic [63:0] V_EX_B = {16'h7FFF, 16'h7FFF, 16'h8000, 16'h8000};
  // p0=2^30, p1=1073676289, p2=2^30, p3=-1073709056
  localparam logic [63:0] V_OR_A = {16'h8000, 16'h8000, 16'h7FFF, 16'h8000};
  localparam logic [63:0] V_OR_B = {16'h7FFF, 16'h8000, 16'h7FFF, 16'h8000};

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!out_valid && in_ready, "R12", {62'd0, out_valid, in_ready}, 64'd1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R12", {62'd0, out_valid, in_ready}, 64'd1);

    // R1: signed -19, unsigned reading of the same bits
    send(V_SM_A, V_SM_B, 1'b1, 1'b0, 2'd0, 1'b0, "R1");
    send(V_SM_A, V_SM_B, 1'b0, 1'b0, 2'd0, 1'b0, "R1");
    // R2: wrap, order and sticky irrelevant, mode 3 too
    send(V_MAXP, V_MAXP, 1'b1, 1'b0, 2'd0, 1'b1, "R2");
    send(V_MAXP, V_MAXP, 1'b1, 1'b1, 2'd3, 1'b0, "R2");
    // R8: limits
    send(V_MAXP, V_MAXP, 1'b1, 1'b0, 2'd1, 1'b0, "R8");
    send(V_MINN, V_MAXP, 1'b1, 1'b1, 2'd2, 1'b0, "R8");
    send(V_ALL1, V_ALL1, 1'b0, 1'b1, 2'd2, 1'b0, "R8");
    send(V_ALL1, V_ALL1, 1'b0, 1'b0, 2'd1, 1'b0, "R8");
    // R3: excursion cancelled, exact 65536, no flags
    send(V_EX_A, V_EX_B, 1'b1, 1'b0, 2'd1, 1'b0, "R3");
    // R7: recovers to 65535 with ovf=1, sat=0
    send(V_EX_A, V_EX_B, 1'b1, 1'b0, 2'd2, 1'b0, "R7");
    // R6: pinned at 0x7FFFFFFF
    send(V_EX_A, V_EX_B, 1'b1, 1'b0, 2'd2, 1'b1, "R6");
    // R5: tree with sticky set behaves like non-sticky
    send(V_EX_A, V_EX_B, 1'b1, 1'b1, 2'd2, 1'b1, "R5");
    // R4 vs R5: left overflows at the second add, tree does not
    send(V_OR_A, V_OR_B, 1'b1, 1'b0, 2'd2, 1'b0, "R4");
    send(V_OR_A, V_OR_B, 1'b1, 1'b1, 2'd2, 1'b0, "R5");
    send(V_OR_A, V_OR_B, 1'b1, 1'b0, 2'd2, 1'b1, "R6");
    send(V_OR_A, V_OR_B, 1'b1, 1'b0, 2'd0, 1'b0, "R2");

    // R9/R10: random back-to-back traffic, timed
    for (int i = 0; i < 150; i++) begin
      logic [1:0] m; logic t, st, s;
      m = 2'($urandom); t = 1'($urandom); st = 1'($urandom); s = 1'($urandom);
      send(pickv(), pickv(), s, t, m, st, tag_of(m, t, st));
    end
    go_idle();
    drain();

    // R11: back-pressure, order only
    cur_timed = 1'b0;
    bp_en = 1'b1;
    for (int i = 0; i < 100; i++) begin
      logic [1:0] m; logic t, st, s;
      m = 2'($urandom); t = 1'($urandom); st = 1'($urandom); s = 1'($urandom);
      send(pickv(), pickv(), s, t, m, st, "R11");
    end
    go_idle();
    @(posedge clk); #2;
    bp_en = 1'b0;
    out_ready = 1'b1;
    drain();
    check(q.size() == 0, "R11", 64'(q.size()), 64'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule